// File: doc/BRIEF.md
# Lockable Security Configuration Register File

This block is the 4 KB register window through which software sets up a memory gating filter. It keeps a small table of 32-bit words, one bit per memory block, that the filter uses to decide which security world may reach each block. Next to the table it holds a control register: whether blocked accesses raise a bus error, whether the table index steps on its own, and a one-way lock. Geometry read-backs tell software how many table words exist and how large a block is. A set of constant identification registers completes the map.

Software reaches the table through a single window register. The word the window shows is chosen by an index register. With auto-stepping enabled, each full-word window access moves the index to the next word, wrapping at the end. Software can therefore stream the whole table through one address. The interrupt registers live in a separate capture block. This block decodes their addresses, returns the capture block's values on reads and turns writes into one-cycle strobes. Each access carries a size (byte, halfword, word) and a non-secure flag. Non-secure accesses reach only the identification registers.

Top module: `sec_cfg_regs`

## Requirements
- R1: After reset the control register reads 0x00000100, the index reads 0, every table word is zero, the lock and security-response outputs are low and no interrupt strobe is active.
- R2: The control register (offset 0x00) keeps only bit 4 (security-response select, driven on `sec_resp_o`), bit 8 (auto-step enable) and bit 31 (lock, driven on `lock_o`); every other bit reads zero whatever was written.
- R3: Once the lock bit is set, writes to the control register, the window (0x1C) and the interrupt-enable register (0x28) have no effect and raise no strobe, until reset; other registers stay writable.
- R4: A non-secure access (`nonsec`=1) to any offset below 0xFD0 reads zero, changes no state, does not step the index and raises no strobe; identification registers read the same from either world.
- R5: Read data appears on `rdata` in the cycle after the request and is zero for write requests; a window read returns the table word selected by the index (0x18), and a window write replaces that word.
- R6: A word-size window access (`size`=2 or 3) with auto-step enabled advances the index by one, wrapping from WORDS-1 to 0; byte and halfword window accesses, accesses with auto-step off and locked window writes leave the index unchanged.
- R7: A write to the index register stores the (merged) written value modulo WORDS.
- R8: Offset 0x10 reads WORDS-1 and offset 0x14 reads BLK_LOG2-5.
- R9: A byte or halfword write to the control, index or window register changes only the addressed bytes; for every other register the bytes not written are taken as zero, so a byte write of 1 to 0x25 does not trigger the clear strobe.
- R10: `size` 0 is a byte at lane `addr[1:0]`, 1 a halfword at lane `addr[1]`, 2 or 3 a full word; sub-word read data is the addressed bytes of the register, right-justified, and sub-word write data is taken from the low bits of `wdata`.
- R11: Reads of 0x20, 0x28, 0x2C and 0x30 return `int_stat_i`, `int_en_i` (in bit 0), `int_addr_i` and `int_attr_i`. A write to 0x28 pulses `ien_we_o` with `ien_val_o` equal to bit 0 of the written value. A write with bit 0 set pulses `iclr_o` (at 0x24) or `iset_o` (at 0x34). Each strobe lasts one cycle, in the cycle after the request.
- R12: The twelve identification registers at 0xFD0+4k (k = 0..11) read 0xA0+k and ignore writes.
- R13: Undefined offsets and the write-only offsets 0x24 and 0x34 read zero, and accesses to undefined offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset in the 4 KB window |
| size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| wdata | input | 32 | Write data, right-justified for sub-word writes |
| nonsec | input | 1 | Access comes from the non-secure world |
| rdata | output | 32 | Read data, registered |
| int_stat_i | input | 1 | Interrupt status from the capture block |
| int_en_i | input | 1 | Interrupt enable from the capture block |
| int_addr_i | input | 32 | Captured address from the capture block |
| int_attr_i | input | 32 | Captured attributes from the capture block |
| ien_we_o | output | 1 | Interrupt-enable write strobe |
| ien_val_o | output | 1 | Value written with `ien_we_o` |
| iclr_o | output | 1 | Interrupt clear strobe |
| iset_o | output | 1 | Interrupt set strobe |
| sec_resp_o | output | 1 | Security-response select to the filter |
| lock_o | output | 1 | Lock state |
| table_o | output | WORDS*32 | Table contents, word 0 in the low bits |

## Verification
The bench builds the block with WORDS=5 and BLK_LOG2=10. A word count that is not a power of two makes the wrap of the auto-stepping index a real modulo, not a dropped carry. The same choice makes the index write's modulo reduction visible for written values of 5 and above. Five words also keep the whole table small enough to stream past the wrap point and compare in full after every access. BLK_LOG2=10 gives a geometry read-back of 5, which differs from the word-count read-back of 4.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam logic [11:0] OFS_CTRL     = 12'h000;
  localparam logic [11:0] OFS_NWORDS   = 12'h010;
  localparam logic [11:0] OFS_GEOM     = 12'h014;
  localparam logic [11:0] OFS_INDEX    = 12'h018;
  localparam logic [11:0] OFS_WINDOW   = 12'h01C;
  localparam logic [11:0] OFS_ISTAT    = 12'h020;
  localparam logic [11:0] OFS_ICLR     = 12'h024;
  localparam logic [11:0] OFS_IEN      = 12'h028;
  localparam logic [11:0] OFS_IADDR    = 12'h02C;
  localparam logic [11:0] OFS_IATTR    = 12'h030;
  localparam logic [11:0] OFS_ISET     = 12'h034;
  localparam logic [11:0] OFS_ID_FIRST = 12'hFD0;

  localparam logic [31:0] CTRL_RESET = 32'h0000_0100;
  localparam logic [31:0] CTRL_KEEP  = 32'h8000_0110;
  localparam int          BIT_RESP   = 4;
  localparam int          BIT_STEP   = 8;
  localparam int          BIT_LOCK   = 31;
  localparam logic [7:0]  ID_BASE    = 8'hA0;
endpackage

// File: rtl/cfg_bytelane.sv
// Byte-lane steering for sub-word accesses (R9, R10).
module cfg_bytelane (
  input  logic [1:0]  addr_lo,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  input  logic [31:0] cur_val,
  output logic [31:0] merged,
  output logic [31:0] zfill,
  output logic [31:0] rd_out
);
  logic [4:0]  sh;
  logic [31:0] mask;
  logic [31:0] wsh;

  always_comb begin
    case (size)
      2'd0: begin
        sh   = {addr_lo, 3'b000};
        mask = 32'h0000_00FF << sh;
      end
      2'd1: begin
        sh   = {addr_lo[1], 4'b0000};
        mask = 32'h0000_FFFF << sh;
      end
      default: begin
        sh   = 5'd0;
        mask = 32'hFFFF_FFFF;
      end
    endcase
    wsh    = (wdata << sh) & mask;
    merged = (cur_val & ~mask) | wsh;
    zfill  = wsh;
    rd_out = (cur_val & mask) >> sh;
  end
endmodule

// File: rtl/cfg_table.sv
// Table storage with its index register (R5, R6, R7).
module cfg_table #(
  parameter int WORDS = 8,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 idx_we,
  input  logic [31:0]          idx_wval,
  input  logic                 win_we,
  input  logic [31:0]          win_wval,
  input  logic                 adv,
  output logic [IDX_W-1:0]     idx_q,
  output logic [31:0]          win_rdata,
  output logic [WORDS*32-1:0]  table_flat
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (idx_we) begin
      idx_q <= IDX_W'(idx_wval % 32'(WORDS));
    end else if (adv) begin
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (win_we) begin
      mem_q[idx_q] <= win_wval;
    end
  end

  assign win_rdata = mem_q[idx_q];

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign table_flat[g*32 +: 32] = mem_q[g];
  end

  // R6/R7: the index never leaves the table
  a_r6_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    32'(idx_q) < 32'(WORDS));
endmodule

// File: rtl/sec_cfg_regs.sv
module sec_cfg_regs
  import cfgreg_pkg::*;
#(
  parameter int WORDS    = 8,
  parameter int BLK_LOG2 = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic                 we,
  input  logic [11:0]          addr,
  input  logic [1:0]           size,
  input  logic [31:0]          wdata,
  input  logic                 nonsec,
  output logic [31:0]          rdata,
  input  logic                 int_stat_i,
  input  logic                 int_en_i,
  input  logic [31:0]          int_addr_i,
  input  logic [31:0]          int_attr_i,
  output logic                 ien_we_o,
  output logic                 ien_val_o,
  output logic                 iclr_o,
  output logic                 iset_o,
  output logic                 sec_resp_o,
  output logic                 lock_o,
  output logic [WORDS*32-1:0]  table_o
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [11:0]      off;
  logic             is_id, allowed, act, wr, rd, word_acc, locked, step_on;
  logic [31:0]      ctrl_q, cur_val, merged, zfill, rd_out, win_rdata;
  logic [IDX_W-1:0] idx_q;
  logic [3:0]       id_k;
  logic             ctrl_we, idx_we, win_we, adv;
  logic [31:0]      rdata_q;
  logic             ien_we_q, ien_val_q, iclr_q, iset_q;

  // Access qualification (R4)
  assign off      = {addr[11:2], 2'b00};
  assign is_id    = (off >= OFS_ID_FIRST);
  assign allowed  = !nonsec || is_id;
  assign act      = req && allowed;
  assign wr       = act && we;
  assign rd       = act && !we;
  assign word_acc = size[1];
  assign locked   = ctrl_q[BIT_LOCK];
  assign step_on  = ctrl_q[BIT_STEP];
  assign id_k     = 4'((off - OFS_ID_FIRST) >> 2);

  // Current register value for reads and sub-word merges (R8, R11, R12, R13)
  always_comb begin
    case (off)
      OFS_CTRL:   cur_val = ctrl_q;
      OFS_NWORDS: cur_val = 32'(WORDS - 1);
      OFS_GEOM:   cur_val = 32'(BLK_LOG2 - 5);
      OFS_INDEX:  cur_val = 32'(idx_q);
      OFS_WINDOW: cur_val = win_rdata;
      OFS_ISTAT:  cur_val = {31'b0, int_stat_i};
      OFS_IEN:    cur_val = {31'b0, int_en_i};
      OFS_IADDR:  cur_val = int_addr_i;
      OFS_IATTR:  cur_val = int_attr_i;
      default:    cur_val = is_id ? {24'b0, ID_BASE + {4'b0, id_k}} : 32'b0;
    endcase
  end

  cfg_bytelane u_lane (
    .addr_lo (addr[1:0]),
    .size    (size),
    .wdata   (wdata),
    .cur_val (cur_val),
    .merged  (merged),
    .zfill   (zfill),
    .rd_out  (rd_out)
  );

  // Write enables with lock gating (R3, R6)
  assign ctrl_we = wr && (off == OFS_CTRL) && !locked;
  assign idx_we  = wr && (off == OFS_INDEX);
  assign win_we  = wr && (off == OFS_WINDOW) && !locked;
  assign adv     = act && (off == OFS_WINDOW) && word_acc && step_on
                   && !(we && locked);

  cfg_table #(.WORDS(WORDS), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .idx_we     (idx_we),
    .idx_wval   (merged),
    .win_we     (win_we),
    .win_wval   (merged),
    .adv        (adv),
    .idx_q      (idx_q),
    .win_rdata  (win_rdata),
    .table_flat (table_o)
  );

  // Control register, read data and interrupt strobes (R1, R2, R5, R11)
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RESET;
      rdata_q   <= '0;
      ien_we_q  <= 1'b0;
      ien_val_q <= 1'b0;
      iclr_q    <= 1'b0;
      iset_q    <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= merged & CTRL_KEEP;
      rdata_q   <= rd ? rd_out : 32'b0;
      ien_we_q  <= wr && (off == OFS_IEN) && !locked;
      ien_val_q <= zfill[0];
      iclr_q    <= wr && (off == OFS_ICLR) && zfill[0];
      iset_q    <= wr && (off == OFS_ISET) && zfill[0];
    end
  end

  assign rdata      = rdata_q;
  assign ien_we_o   = ien_we_q;
  assign ien_val_o  = ien_val_q;
  assign iclr_o     = iclr_q;
  assign iset_o     = iset_q;
  assign sec_resp_o = ctrl_q[BIT_RESP];
  assign lock_o     = locked;

  // R3: lock holds until reset and freezes the table and enable writes
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> lock_o);
  a_r3_table_frozen: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> $stable(table_o));
  a_r3_no_ien_strobe: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> !ien_we_o);
  // R4: non-secure access below the ID range is invisible
  a_r4_ns_read_zero: assert property (@(posedge clk) disable iff (rst)
    (req && !we && nonsec && addr < OFS_ID_FIRST) |=> (rdata == 32'b0));
  a_r4_ns_no_effect: assert property (@(posedge clk) disable iff (rst)
    (req && nonsec && addr < OFS_ID_FIRST) |=>
      ($stable(table_o) && $stable(sec_resp_o) && !iclr_o && !iset_o && !ien_we_o));
  // R11: strobes are single-cycle pulses of one kind
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ien_we_o, iclr_o, iset_o}));
endmodule

// File: tb/sec_cfg_regs_tb.sv
module sec_cfg_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 5;
  localparam int BL = 10;

  logic clk = 1'b0;
  logic rst, req, we, nonsec;
  logic [11:0] addr;
  logic [1:0]  size;
  logic [31:0] wdata, rdata;
  logic        st_i, en_i;
  logic [31:0] ia_i, it_i;
  logic        ien_we_o, ien_val_o, iclr_o, iset_o, sec_resp_o, lock_o;
  logic [W*32-1:0] table_o;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_ctrl;
  int          m_idx;
  logic [31:0] m_tab [W];

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_cfg_regs #(.WORDS(W), .BLK_LOG2(BL)) u_dut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .size(size),
    .wdata(wdata), .nonsec(nonsec), .rdata(rdata),
    .int_stat_i(st_i), .int_en_i(en_i), .int_addr_i(ia_i), .int_attr_i(it_i),
    .ien_we_o(ien_we_o), .ien_val_o(ien_val_o), .iclr_o(iclr_o), .iset_o(iset_o),
    .sec_resp_o(sec_resp_o), .lock_o(lock_o), .table_o(table_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cur(input logic [11:0] off);
    case (off)
      12'h000: return m_ctrl;
      12'h010: return 32'(W - 1);
      12'h014: return 32'(BL - 5);
      12'h018: return 32'(m_idx);
      12'h01C: return m_tab[m_idx];
      12'h020: return {31'b0, st_i};
      12'h028: return {31'b0, en_i};
      12'h02C: return ia_i;
      12'h030: return it_i;
      default: return (off >= 12'hFD0) ? 32'(8'hA0 + (off - 12'hFD0) / 4) : 32'b0;
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1; req = 1'b0; we = 1'b0; addr = '0; size = 2'd2;
    wdata = '0; nonsec = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_ctrl = 32'h0000_0100;
    m_idx  = 0;
    for (int i = 0; i < W; i++) m_tab[i] = '0;
  endtask

  task automatic check_state(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < W; i++)
      if (table_o[i*32 +: 32] !== m_tab[i]) bad = i;
    chk(sec_resp_o === m_ctrl[4] && lock_o === m_ctrl[31],
        {tag, " R2 ctrl outputs"}, {30'b0, lock_o, sec_resp_o},
        {30'b0, m_ctrl[31], m_ctrl[4]});
    if (bad >= 0)
      chk(1'b0, {tag, " R5 table"}, table_o[bad*32 +: 32], m_tab[bad]);
    else
      chk(1'b1, tag, 0, 0);
  endtask

  task automatic acc(input bit w, input logic [11:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input bit ns, input string tag);
    logic [11:0] off;
    bit ok;
    int sh;
    logic [31:0] mask, cv, wsh, mg, exp_rd;
    bit e_ien, e_val, e_clr, e_set, lk;
    off = {a[11:2], 2'b00};
    ok  = !ns || off >= 12'hFD0;
    if (sz == 2'd0)      begin sh = 8 * a[1:0]; mask = 32'hFF << sh; end
    else if (sz == 2'd1) begin sh = 16 * a[1];  mask = 32'hFFFF << sh; end
    else                 begin sh = 0;          mask = 32'hFFFF_FFFF; end
    cv  = cur(off);
    wsh = (d << sh) & mask;
    mg  = (cv & ~mask) | wsh;
    exp_rd = (ok && !w) ? ((cv & mask) >> sh) : 32'b0;
    lk = m_ctrl[31];
    e_ien = 0; e_val = 0; e_clr = 0; e_set = 0;
    if (ok && w) begin
      case (off)
        12'h000: if (!lk) m_ctrl = mg & 32'h8000_0110;
        12'h018: m_idx = int'(mg % W);
        12'h01C: if (!lk) m_tab[m_idx] = mg;
        12'h028: if (!lk) begin e_ien = 1; e_val = wsh[0]; end
        12'h024: e_clr = wsh[0];
        12'h034: e_set = wsh[0];
        default: ;
      endcase
    end
    if (ok && off == 12'h01C && sz[1] && cv !== 32'hx && m_ctrl[8] && !(w && lk))
      m_idx = (m_idx + 1) % W;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d; nonsec = ns;
    @(negedge clk);
    req = 1'b0;
    chk(rdata === exp_rd, {tag, " R5 rdata"}, rdata, exp_rd);
    chk(ien_we_o === e_ien && iclr_o === e_clr && iset_o === e_set &&
        (!e_ien || ien_val_o === e_val), {tag, " R11 strobes"},
        {28'b0, ien_we_o, ien_val_o, iclr_o, iset_o},
        {28'b0, e_ien, e_val, e_clr, e_set});
    check_state(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    st_i = 1'b1; en_i = 1'b0; ia_i = 32'hCAFE_0123; it_i = 32'h0002_0045;
    do_reset();

    // R1: reset state
    @(negedge clk);
    chk(rdata === 32'b0 && !ien_we_o && !iclr_o && !iset_o, "R1 outputs idle", rdata, 0);
    check_state("R1");
    acc(0, 12'h000, 2, 0, 0, "R1 ctrl");
    acc(0, 12'h018, 2, 0, 0, "R1 index");

    // R8: geometry
    acc(0, 12'h010, 2, 0, 0, "R8 nwords");
    acc(0, 12'h014, 2, 0, 0, "R8 geom");

    // R6/R5: stream writes past the wrap
    for (int i = 0; i <= W; i++)
      acc(1, 12'h01C, 2, 32'h1111_0000 + i, 0, "R6 stream write");
    acc(0, 12'h018, 2, 0, 0, "R6 wrapped index");
    for (int i = 0; i < W; i++)
      acc(0, 12'h01C, 2, 0, 0, "R5 stream read");

    // R7: index modulo
    acc(1, 12'h018, 2, 32'd7, 0, "R7 idx mod");
    acc(0, 12'h018, 2, 0, 0, "R7 idx read");

    // R9/R10: sub-word window
    acc(1, 12'h01D, 0, 32'hAB, 0, "R9 byte merge");
    acc(0, 12'h01E, 1, 0, 0, "R10 half read");
    acc(0, 12'h01D, 0, 0, 0, "R10 byte read");
    acc(1, 12'h01E, 1, 32'hBEEF, 0, "R9 half merge");
    acc(0, 12'h01C, 2, 0, 0, "R6 word read steps");

    // R2/R9: ctrl fields and merge
    acc(1, 12'h000, 2, 32'h7FFF_FEFF, 0, "R2 reserved bits");
    acc(0, 12'h000, 2, 0, 0, "R2 ctrl read");
    acc(1, 12'h001, 0, 32'h01, 0, "R9 ctrl byte");
    acc(1, 12'h000, 0, 32'h00, 0, "R9 ctrl byte clr resp");
    acc(1, 12'h001, 0, 32'h00, 0, "R6 step off");
    acc(0, 12'h01C, 2, 0, 0, "R6 no step");
    acc(0, 12'h018, 2, 0, 0, "R6 idx held");
    acc(1, 12'h000, 2, 32'h0000_0110, 0, "R2 restore");

    // R11: interrupt decode
    acc(0, 12'h020, 2, 0, 0, "R11 stat");
    acc(0, 12'h028, 2, 0, 0, "R11 en");
    acc(0, 12'h02C, 2, 0, 0, "R11 addr");
    acc(0, 12'h031, 0, 0, 0, "R11 attr byte");
    acc(1, 12'h024, 2, 1, 0, "R11 clear");
    acc(1, 12'h025, 0, 1, 0, "R9 zero fill clear");
    acc(1, 12'h034, 0, 1, 0, "R11 set");
    acc(1, 12'h028, 2, 1, 0, "R11 enable");
    acc(1, 12'h028, 2, 0, 0, "R11 disable");

    // R4: non-secure
    acc(1, 12'h000, 2, 32'h8000_0000, 1, "R4 ns ctrl write");
    acc(0, 12'h01C, 2, 0, 1, "R4 ns window read");
    acc(1, 12'h01C, 2, 32'hDEAD, 1, "R4 ns window write");
    acc(1, 12'h024, 2, 1, 1, "R4 ns clear");
    acc(0, 12'h018, 2, 0, 0, "R4 idx unchanged");
    acc(0, 12'hFD0, 2, 0, 1, "R4 ns id read");

    // R12/R13
    acc(0, 12'hFFC, 2, 0, 0, "R12 last id");
    acc(1, 12'hFE0, 2, 32'h55, 0, "R12 id write");
    acc(0, 12'hFE0, 2, 0, 0, "R12 id read");
    acc(0, 12'h040, 2, 0, 0, "R13 undefined read");
    acc(1, 12'h040, 2, 32'hFFFF_FFFF, 0, "R13 undefined write");
    acc(0, 12'h024, 2, 0, 0, "R13 wo clear read");
    acc(0, 12'h034, 2, 0, 0, "R13 wo set read");

    // Random mix (R5/R9/R10)
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      int pick;
      pick = $urandom_range(0, 13);
      case (pick)
        0: a = 12'h010; 1: a = 12'h014; 2: a = 12'h018; 3: a = 12'h01C;
        4: a = 12'h01C; 5: a = 12'h020; 6: a = 12'h024; 7: a = 12'h028;
        8: a = 12'h02C; 9: a = 12'h030; 10: a = 12'h034;
        11: a = 12'hFD0 + 12'(4 * $urandom_range(0, 11));
        12: a = 12'h000;
        default: a = 12'(($urandom_range(0, 1000) * 4) + 12'h038);
      endcase
      a[1:0] = 2'($urandom_range(0, 3));
      d = $urandom;
      if (pick == 12) begin
        acc(1, 12'h000, 2, d & 32'h0000_0110, 1'($urandom_range(0, 3) == 0),
            "R2 random ctrl");
      end else begin
        acc(1'($urandom_range(0, 1)), a, 2'($urandom_range(0, 3)), d,
            1'($urandom_range(0, 3) == 0), "R5/R9/R10 random");
      end
    end

    // R3: lockdown
    acc(1, 12'h000, 2, 32'h8000_0110, 0, "R3 lock set");
    acc(1, 12'h000, 2, 32'h0000_0000, 0, "R3 ctrl frozen");
    acc(0, 12'h000, 2, 0, 0, "R3 ctrl read");
    acc(1, 12'h01C, 2, 32'h1234_5678, 0, "R3 window frozen");
    acc(1, 12'h028, 2, 1, 0, "R3 enable frozen");
    acc(1, 12'h018, 2, 32'd3, 0, "R3 idx writable");
    acc(0, 12'h01C, 2, 0, 0, "R3 locked read steps");
    acc(0, 12'h018, 2, 0, 0, "R3 idx after read");
    acc(1, 12'h034, 2, 1, 0, "R3 set still works");
    do_reset();
    @(negedge clk);
    check_state("R1 after lock reset");
    acc(0, 12'h000, 2, 0, 0, "R1 ctrl after reset");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule